// File: doc/BRIEF.md
# Legacy CPU Socket Bus Bridge

This block sits between a newer host processor, running in its legacy-compatible bus mode, and the 8-bit CPU socket of an existing board. The host drives a 24-bit address, a one-clock address strobe and level strobes for memory, I/O, read and write. The block decides where each cycle goes. A memory cycle whose top address bit is set is served by on-board expansion memory, which covers the upper half of host space. All other cycles go to the socket, and the lowest 64 KB of host space is the legacy address space.

For socket cycles the block captures the low 16 address bits when the address strobe arrives and drives them for the whole cycle. It presents registered, glitch-free active-low strobes one host clock after the host strobes. For expansion cycles it raises a local select and keeps every socket strobe inactive, so the outside system never sees the access.

The host core clock runs at four times the socket clock. A phase tick input, high for one host clock per socket clock period, marks the point where a legacy CPU would sample the socket WAIT line. The block samples WAIT only at that point and holds the sample for one socket period toward the host. This moves the wait decision back to where the external wait generators expect it. No opcode-fetch indication is produced at the socket.

Top module: `sock_bridge`

## Requirements
- R1: Under synchronous active-low reset, all four socket strobes are high (inactive), local_sel and host_wait are low, and sock_addr is zero.
- R2: When host_as is high at a clock edge and no cycle is in progress, sock_addr takes host_addr[15:0] at that edge. It holds that value until the next accepted address strobe.
- R3: An address strobe that arrives while a socket strobe or local_sel is active is ignored, and sock_addr does not change.
- R4: For a memory cycle latched with host_addr[23]=0, sock_mreq_n, sock_rd_n and sock_wr_n follow the inverted host_mreq, host_rd and host_wr one clock later, and local_sel stays low.
- R5: For a memory cycle latched with host_addr[23]=1, local_sel follows host_mreq one clock later, and sock_mreq_n, sock_iorq_n, sock_rd_n and sock_wr_n all stay high for the whole cycle.
- R6: I/O cycles always go to the socket, whatever the value of address bit 23. sock_iorq_n and the read or write strobe go low one clock after the host strobes, and local_sel stays low.
- R7: sock_wait_n is sampled only at clock edges where phase_tick is high and a socket strobe is active. host_wait shows that sample from the next clock until the next phase tick, and the level of sock_wait_n between ticks has no effect.
- R8: If sock_wait_n is low at N consecutive sampling ticks of a socket cycle, host_wait is high for exactly N socket clock periods (N x 4 host clocks).
- R9: host_wait is low whenever no socket strobe is active, including during expansion-memory cycles, whatever the level of sock_wait_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_tick | input | 1 | One-clock pulse per socket clock period; legacy WAIT sampling point |
| host_addr | input | 24 | Host address |
| host_as | input | 1 | Host address strobe, one clock per bus cycle |
| host_mreq | input | 1 | Host memory request, active high |
| host_iorq | input | 1 | Host I/O request, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_wait | output | 1 | Retimed wait toward the host, active high |
| sock_addr | output | 16 | Latched address driven to the socket |
| sock_mreq_n | output | 1 | Socket memory request, active low |
| sock_iorq_n | output | 1 | Socket I/O request, active low |
| sock_rd_n | output | 1 | Socket read, active low |
| sock_wr_n | output | 1 | Socket write, active low |
| sock_wait_n | input | 1 | Socket WAIT from external logic, active low |
| local_sel | output | 1 | Expansion memory select, active high |

## Verification
The hardest situation to reach is an expansion-memory cycle during which the socket WAIT line is held low by a careless external wait generator. Only a missing gate on host_wait would show it, as a host stall that never ends. The stimulus drives random levels on sock_wait_n through every expansion cycle, including the tick cycles. The wait count, the strobe levels and the local select are then checked against the expected quiet behaviour. Socket cycles also carry random wait levels between ticks and a directed count of asserted ticks, and some cycles carry a stray address strobe in the middle.

// File: rtl/sock_bridge_pkg.sv
// Package: shared types and default sizes for the socket bus bridge.
// Assumes the host strobes are active high and mutually exclusive between
// memory and I/O requests.
package sock_bridge_pkg;

    // Default geometry of the host and socket address buses
    localparam int HOST_AW_DEF = 24;
    localparam int SOCK_AW_DEF = 16;

    // Bundle of bus control strobes, active high inside the block
    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
    } strb_t;

endpackage

// File: rtl/sbr_addr_latch.sv
// Module: address latch and space decode.
// Captures the low address bits and the expansion-space bit on an accepted
// address strobe. A strobe that arrives while a cycle is in progress is
// dropped. Assumes the host holds the address stable during the strobe clock.
module sbr_addr_latch #(
    parameter int HOST_AW = 24,
    parameter int SOCK_AW = 16,
    parameter int SEL_BIT = HOST_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               as_in,
    input  logic               busy,
    input  logic [HOST_AW-1:0] addr_in,
    output logic [SOCK_AW-1:0] addr_q,
    output logic               ext_space
);

    logic take;
    assign take = as_in & ~busy;

    // Latch the socket address and the steering bit on an accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            ext_space <= 1'b0;
        end else if (take) begin
            addr_q    <= addr_in[SOCK_AW-1:0];
            ext_space <= addr_in[SEL_BIT];
        end
    end

    // Address bits that neither reach the socket nor steer the cycle
    generate
        if (SEL_BIT > SOCK_AW) begin : g_mid
            logic unused_mid;
            assign unused_mid = ^addr_in[SEL_BIT-1:SOCK_AW];
        end
        if (HOST_AW - 1 > SEL_BIT) begin : g_top
            logic unused_top;
            assign unused_top = ^addr_in[HOST_AW-1:SEL_BIT+1];
        end
    endgenerate

endmodule

// File: rtl/sbr_strobe_gate.sv
// Module: strobe steering and cleanup.
// Registers the host strobes and sends them either to the socket or to the
// expansion memory select. I/O cycles always go to the socket. Socket
// outputs are active low and come from flops, so they cannot glitch.
module sbr_strobe_gate
    import sock_bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  strb_t host_s,
    input  logic  ext_space,
    output strb_t sock_s_n,
    output logic  local_sel
);

    logic  mem_local;
    logic  to_sock;
    strb_t nxt_n;

    // Decide where the current host strobes belong
    always_comb begin
        mem_local  = host_s.mreq & ext_space;
        to_sock    = host_s.iorq | (host_s.mreq & ~ext_space);
        nxt_n.mreq = ~(host_s.mreq & ~ext_space);
        nxt_n.iorq = ~host_s.iorq;
        nxt_n.rd   = ~(host_s.rd & to_sock);
        nxt_n.wr   = ~(host_s.wr & to_sock);
    end

    // Register the cleaned socket strobes and the local select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sock_s_n  <= '1;
            local_sel <= 1'b0;
        end else begin
            sock_s_n  <= nxt_n;
            local_sel <= mem_local;
        end
    end

endmodule

// File: rtl/sbr_wait_retime.sv
// Module: WAIT retiming.
// Samples the socket WAIT only on the legacy sampling tick while a socket
// cycle is running. The sample is held for one socket period toward the host.
// Assumes sock_wait_n is settled at the tick edge, because external logic
// times it from the same socket clock.
module sbr_wait_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_tick,
    input  logic sock_act,
    input  logic sock_wait_n,
    output logic host_wait
);

    logic wait_q;

    // Take a new WAIT sample at each legacy sampling point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
        end else if (phase_tick) begin
            wait_q <= sock_act & ~sock_wait_n;
        end
    end

    // Pass the held sample on only while the socket is being driven
    assign host_wait = wait_q & sock_act;

endmodule

// File: rtl/sock_bridge.sv
// Module: top of the socket bus bridge.
// Joins the address latch, the strobe steering and the WAIT retiming.
// Assumes the host raises host_as only while its strobes are low, and raises
// its strobes one clock or more after the address strobe.
module sock_bridge
    import sock_bridge_pkg::*;
#(
    parameter int HOST_AW = HOST_AW_DEF,
    parameter int SOCK_AW = SOCK_AW_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_tick,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_as,
    input  logic               host_mreq,
    input  logic               host_iorq,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic               host_wait,
    output logic [SOCK_AW-1:0] sock_addr,
    output logic               sock_mreq_n,
    output logic               sock_iorq_n,
    output logic               sock_rd_n,
    output logic               sock_wr_n,
    input  logic               sock_wait_n,
    output logic               local_sel
);

    localparam int SEL_BIT = HOST_AW - 1;

    strb_t host_s;
    strb_t sock_s_n;
    logic  ext_space;
    logic  sock_act;
    logic  busy;

    // Gather the host strobes into one bundle
    always_comb begin
        host_s.mreq = host_mreq;
        host_s.iorq = host_iorq;
        host_s.rd   = host_rd;
        host_s.wr   = host_wr;
    end

    // A socket cycle is running while either request strobe is low
    assign sock_act = ~sock_s_n.mreq | ~sock_s_n.iorq;
    assign busy     = sock_act | local_sel;

    sbr_addr_latch #(
        .HOST_AW (HOST_AW),
        .SOCK_AW (SOCK_AW),
        .SEL_BIT (SEL_BIT)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_in     (host_as),
        .busy      (busy),
        .addr_in   (host_addr),
        .addr_q    (sock_addr),
        .ext_space (ext_space)
    );

    sbr_strobe_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_s    (host_s),
        .ext_space (ext_space),
        .sock_s_n  (sock_s_n),
        .local_sel (local_sel)
    );

    sbr_wait_retime u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_tick  (phase_tick),
        .sock_act    (sock_act),
        .sock_wait_n (sock_wait_n),
        .host_wait   (host_wait)
    );

    // Drive the socket pins from the registered strobe bundle
    assign sock_mreq_n = sock_s_n.mreq;
    assign sock_iorq_n = sock_s_n.iorq;
    assign sock_rd_n   = sock_s_n.rd;
    assign sock_wr_n   = sock_s_n.wr;

endmodule

// File: rtl/sock_bridge_chk.sv
// Module: property checker for the socket bus bridge, bound to the top.
// Looks only at the ports of the top module.
module sock_bridge_chk #(
    parameter int HOST_AW = 24,
    parameter int SOCK_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               phase_tick,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_as,
    input logic               host_mreq,
    input logic               host_iorq,
    input logic               host_rd,
    input logic               host_wr,
    input logic               host_wait,
    input logic [SOCK_AW-1:0] sock_addr,
    input logic               sock_mreq_n,
    input logic               sock_iorq_n,
    input logic               sock_rd_n,
    input logic               sock_wr_n,
    input logic               sock_wait_n,
    input logic               local_sel
);

    logic act;
    assign act = !sock_mreq_n || !sock_iorq_n;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (sock_mreq_n && sock_iorq_n && sock_rd_n && sock_wr_n
                    && !local_sel && !host_wait)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act || local_sel) |=> $stable(sock_addr)); // R3

    AST_LOCAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        local_sel |-> (sock_mreq_n && sock_iorq_n && sock_rd_n && sock_wr_n)); // R5

    AST_IO_TO_SOCKET: assert property (@(posedge clk) disable iff (!rst_n)
        host_iorq |=> (!sock_iorq_n && !local_sel)); // R6

    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_tick && act) |=> (!act || $stable(host_wait))); // R7

    AST_WAIT_NEEDS_SOCKET: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> act); // R9

endmodule

bind sock_bridge sock_bridge_chk #(.HOST_AW(HOST_AW), .SOCK_AW(SOCK_AW)) u_chk (.*);

// File: tb/tb_sock_bridge.sv
// Bench: host bus model, socket wait generator with stray levels, and
// per-cycle checks against values derived from the requirements.
module tb_sock_bridge;

    localparam int PH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_tick = 1'b0;
    logic [23:0] host_addr = '0;
    logic        host_as = 1'b0, host_mreq = 1'b0, host_iorq = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic        host_wait;
    logic [15:0] sock_addr;
    logic        sock_mreq_n, sock_iorq_n, sock_rd_n, sock_wr_n;
    logic        sock_wait_n = 1'b1;
    logic        local_sel;

    int n_chk = 0;
    int n_fail = 0;
    int phase_cnt = 0;
    bit act_now = 0, prev_act = 0, prev_tick = 0, prev_wn = 1;
    bit exp_q = 0;
    bit wmodel_err = 0;

    always #5 clk = ~clk;

    sock_bridge dut (.*);

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
        end
    endtask

    // Advance one clock, update the WAIT model, pick the next phase tick
    task automatic step();
        prev_tick = phase_tick;
        prev_act  = act_now;
        prev_wn   = sock_wait_n;
        @(negedge clk);
        if (!rst_n) exp_q = 0;
        else if (prev_tick) exp_q = prev_act & ~prev_wn;
        act_now = !sock_mreq_n || !sock_iorq_n;
        if (host_wait !== (exp_q & act_now)) wmodel_err = 1;
        phase_cnt++;
        phase_tick = (phase_cnt % PH) == 0;
    endtask

    // One host bus cycle; poke adds a stray address strobe mid-cycle
    task automatic run_cycle(input logic [23:0] a, input bit io, input bit wr,
                             input int nwait, input bit poke);
        bit loc = !io && a[23];
        int cnt = 0, ticks = 0, left = nwait, it = 0;
        bit strb_err = 0, addr_err = 0;
        step();
        host_as = 1; host_addr = a; sock_wait_n = 1;
        step();
        host_as = 0;
        host_mreq = !io; host_iorq = io; host_rd = !wr; host_wr = wr;
        chk(sock_addr == a[15:0], "R2 address latched", sock_addr, a[15:0]);
        wmodel_err = 0;
        forever begin
            step();
            it++;
            if (sock_addr != a[15:0]) addr_err = 1;
            if (sock_mreq_n != (io || loc) || sock_iorq_n != !io ||
                sock_rd_n != !(!wr && !loc) || sock_wr_n != !(wr && !loc) ||
                local_sel != loc) strb_err = 1;
            if (host_wait) cnt++;
            if (poke && it == 3) begin
                host_as = 1; host_addr = a ^ 24'h00ffff;
            end else begin
                host_as = 0; host_addr = a;
            end
            if (phase_tick && (loc || act_now)) ticks++;
            if (!loc && phase_tick && act_now) begin
                sock_wait_n = (left > 0) ? 1'b0 : 1'b1;
                if (left > 0) left--;
            end else begin
                sock_wait_n = 1'($urandom % 2);
            end
            if (ticks >= nwait + 2 && !host_wait && it > 4) break;
        end
        host_as = 0; host_addr = a;
        host_mreq = 0; host_iorq = 0; host_rd = 0; host_wr = 0;
        step();
        sock_wait_n = 1;
        chk(!addr_err, poke ? "R3 stray strobe ignored, address held" : "R2 address held",
            addr_err, 0);
        if (loc)
            chk(!strb_err, "R5 expansion cycle: socket silent, local_sel on", strb_err, 0);
        else if (io)
            chk(!strb_err, "R6 I/O cycle on socket", strb_err, 0);
        else
            chk(!strb_err, "R4 memory cycle on socket", strb_err, 0);
        if (loc)
            chk(cnt == 0, "R9 no host wait in expansion cycle", cnt, 0);
        else
            chk(cnt == PH * nwait, "R8 wait extension length", cnt, PH * nwait);
        chk(!wmodel_err, "R7 wait sampled only at ticks, held between", wmodel_err, 0);
        chk(sock_mreq_n && sock_iorq_n && sock_rd_n && sock_wr_n && !local_sel && !host_wait,
            "R9 idle after cycle: strobes released, no wait",
            {sock_mreq_n, sock_iorq_n, sock_rd_n, sock_wr_n, local_sel, host_wait}, 6'b111100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (all requirements) act=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        sock_wait_n = 0;
        repeat (4) step();
        chk(sock_mreq_n && sock_iorq_n && sock_rd_n && sock_wr_n,
            "R1 reset strobes inactive",
            {sock_mreq_n, sock_iorq_n, sock_rd_n, sock_wr_n}, 4'hf);
        chk(!local_sel && !host_wait && sock_addr == 0, "R1 reset select, wait, address",
            {local_sel, host_wait, sock_addr}, 0);
        sock_wait_n = 1;
        rst_n = 1;
        step();
        chk(!host_wait, "R9 idle with no cycle", host_wait, 0);
        // directed corner cases
        run_cycle(24'h001234, 0, 0, 0, 0);
        run_cycle(24'h00ABCD, 0, 1, 2, 0);
        run_cycle(24'h80F00D, 0, 0, 0, 0);
        run_cycle(24'hFFFFFF, 0, 1, 0, 1);
        run_cycle(24'h8000FE, 1, 0, 1, 0);
        run_cycle(24'h0000FE, 1, 1, 3, 1);
        run_cycle(24'h7FFFFF, 0, 0, 1, 1);
        // random cycles
        for (int i = 0; i < 60; i++) begin
            logic [23:0] a = 24'($urandom);
            bit io = ($urandom % 4) == 0;
            bit wr = 1'($urandom % 2);
            bit loc = !io && a[23];
            int nw = loc ? 0 : int'($urandom % 4);
            run_cycle(a, io, wr, nw, ($urandom % 5) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule